// File: doc/BRIEF.md
# QPSK Phase-Selection Modulator

The block turns a serial bit stream into a sampled QPSK carrier, one signed 16-bit word per clock, ready for an external digital-to-analog converter. Incoming bits are gathered in pairs, and the first bit of each pair is the most significant bit of the symbol. Each pair is Gray mapped to one of four quarter-turn phase positions. The carrier comes from a direct digital synthesis phase accumulator feeding a cosine lookup table. Modulation uses no multipliers. The symbol's quarter-turn offset is added to the accumulator phase before the table lookup.

The carrier runs at 8 samples per cycle, and each symbol lasts 5 carrier cycles, which is 40 samples. Symbols change only at a symbol boundary, and every symbol starts at accumulator phase zero, so the carrier is locked to symbol timing. The source offers bits through a valid/ready handshake, and the block holds at most one pending symbol. If no complete symbol is waiting at a boundary, the current phase is kept and a one-clock underrun pulse is raised.

After reset the first symbol period carries phase 0°, and data symbols follow from the second period on.

Top module: `qpsk_phase_mod`

## Requirements
- R1: A bit is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high while fewer than two bits are pending, and bits offered while it is low are not taken. The first accepted bit of a pair becomes the symbol MSB.
- R2: A pending symbol maps to quarter index q with a Gray code: 00→0 (0°), 01→1 (90°), 11→2 (180°), 10→3 (270°). The phase offset is q quarter-turns, which is 2q steps of the 8-entry cosine table.
- R3: Output sample j (j counted from 0 after reset) equals T[(j + 2q) mod 8], where q is the quarter index in force for that sample. The table is T = {32767, 23170, 0, −23170, −32767, −23170, 0, 23170}.
- R4: A symbol lasts 40 samples, and a new quarter index takes effect only from samples j = 40m (m ≥ 1). The pending symbol is consumed at that boundary, and `in_ready` rises again.
- R5: If two bits are not pending when a boundary is crossed, the previous quarter index is kept for the next 40 samples. `underrun` is then high for exactly the one clock that follows that boundary edge, and it is low at all other times.
- R6: During reset `sample_out` is 0, `sample_valid` is 0, `underrun` is 0 and `in_ready` is 1. After reset the first symbol period uses q = 0, so the first sample is +32767.
- R7: `sample_valid` is low after the first clock edge following reset release. It goes high after the second edge and stays high. Sample j appears after edge j+2.
- R8: Every valid output word lies within −32767 to +32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one output word per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Source offers a bit |
| in_bit | input | 1 | Offered data bit |
| in_ready | output | 1 | Block can take a bit this cycle |
| sample_out | output | 16 | Signed carrier sample |
| sample_valid | output | 1 | `sample_out` holds a valid sample |
| underrun | output | 1 | One-clock pulse when a boundary finds no symbol |

## Verification
Assertions check the following on every cycle:
- the pending count grows by one on each accepted bit;
- a consumed symbol frees the input;
- the accumulator is at zero whenever the sample counter is at zero;
- an underrun pulse lasts one clock and leaves the phase index unchanged;
- `sample_valid` never drops once it is high;
- output words stay within the peak amplitude.

Only the bench scenarios can show the following:
- the Gray mapping of each pair;
- the MSB-first bit order;
- the exact table value of every sample;
- the 40-sample symbol timing;
- the two-cycle output latency.

The bench scenarios do this by comparing each output word against a model built from the requirements, including runs where data arrives late or runs out.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;
  localparam int PHASE_W      = 8;
  localparam int SAMP_PER_CYC = 8;
  localparam int CYC_PER_SYM  = 5;
  localparam int OUT_W        = 16;
  localparam int PEAK         = 32767;
  localparam int DIAG         = 23170;  // round(PEAK / sqrt(2))
  localparam int SYM_W        = 2;

  localparam int LUT_AW       = $clog2(SAMP_PER_CYC);
  localparam int PHASE_STEP   = (1 << PHASE_W) / SAMP_PER_CYC;
  localparam int SAMP_PER_SYM = SAMP_PER_CYC * CYC_PER_SYM;
  localparam int CNT_W        = $clog2(SAMP_PER_SYM);

  typedef logic [1:0] quarter_t;

  // Gray-coded symbol to quarter-turn index
  function automatic quarter_t gray_to_quarter(logic [1:0] s);
    return {s[1], s[1] ^ s[0]};
  endfunction
endpackage

// File: rtl/qpsk_sym_collect.sv
module qpsk_sym_collect
  import qpsk_pkg::*;
#(
  parameter int BITS = SYM_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_bit,
  input  logic            take,
  output logic            in_ready,
  output logic            full,
  output logic [BITS-1:0] sym
);
  localparam int CW = $clog2(BITS + 1);

  logic [CW-1:0]   count_q, count_d;
  logic [BITS-1:0] shift_q, shift_d;
  logic            accept;

  assign full     = (count_q == CW'(BITS));
  assign in_ready = !full;
  assign accept   = in_valid && in_ready;
  assign sym      = shift_q;

  always_comb begin
    shift_d = shift_q;
    count_d = count_q;
    if (take) begin
      count_d = '0;
    end else if (accept) begin
      shift_d = {shift_q[BITS-2:0], in_bit};
      count_d = count_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      shift_q <= '0;
    end else begin
      count_q <= count_d;
      if (accept) shift_q <= shift_d;
    end
  end

  p_accept_counts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (count_q == $past(count_q) + CW'(1)));

  p_take_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (in_ready && count_q == '0));
endmodule

// File: rtl/qpsk_phase_gen.sv
module qpsk_phase_gen
  import qpsk_pkg::*;
#(
  parameter int PW   = PHASE_W,
  parameter int STEP = PHASE_STEP,
  parameter int NSYM = SAMP_PER_SYM,
  parameter int CW   = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full,
  input  logic [1:0]    sym,
  output logic          take,
  output logic [PW-1:0] phase,
  output logic          underrun
);
  localparam logic [CW-1:0] LAST = CW'(NSYM - 1);

  logic [PW-1:0] acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  quarter_t      quarter_q, quarter_d;
  logic          under_q, under_d;
  logic          boundary;
  logic          adv_en;

  assign adv_en   = 1'b1;
  assign boundary = (cnt_q == LAST);
  assign take     = boundary && full;
  assign phase    = acc_q + {quarter_q, {(PW-2){1'b0}}};
  assign underrun = under_q;

  always_comb begin
    acc_d     = acc_q + PW'(STEP);
    cnt_d     = boundary ? '0 : cnt_q + CW'(1);
    quarter_d = take ? gray_to_quarter(sym) : quarter_q;
    under_d   = boundary && !full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      quarter_q <= '0;
      under_q   <= 1'b0;
    end else if (adv_en) begin
      acc_q     <= acc_d;
      cnt_q     <= cnt_d;
      quarter_q <= quarter_d;
      under_q   <= under_d;
    end
  end

  p_symstart_phase_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (acc_q == '0));

  p_underrun_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    under_q |-> (quarter_q == $past(quarter_q)));

  p_underrun_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    under_q |=> !under_q);
endmodule

// File: rtl/qpsk_sine_lut.sv
module qpsk_sine_lut
  import qpsk_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int AW = LUT_AW,
  parameter int OW = OUT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        phase,
  output logic signed [OW-1:0] sample_out,
  output logic                 sample_valid
);
  logic [AW-1:0]        addr_q;
  logic                 v1_q, v2_q;
  logic signed [OW-1:0] samp_q, samp_d;

  function automatic logic signed [OW-1:0] cos_at(logic [AW-1:0] a);
    case (a)
      AW'(0):  return OW'(PEAK);
      AW'(1):  return OW'(DIAG);
      AW'(2):  return '0;
      AW'(3):  return OW'(-DIAG);
      AW'(4):  return OW'(-PEAK);
      AW'(5):  return OW'(-DIAG);
      AW'(6):  return '0;
      AW'(7):  return OW'(DIAG);
      default: return '0;
    endcase
  endfunction

  always_comb samp_d = cos_at(addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      samp_q <= '0;
    end else begin
      addr_q <= phase[PW-1 -: AW];
      v1_q   <= 1'b1;
      v2_q   <= v1_q;
      if (v1_q) samp_q <= samp_d;
    end
  end

  assign sample_out   = samp_q;
  assign sample_valid = v2_q;

  p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    v2_q |=> v2_q);

  p_amp_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    v2_q |-> (samp_q >= OW'(-PEAK) && samp_q <= OW'(PEAK)));
endmodule

// File: rtl/qpsk_phase_mod.sv
module qpsk_phase_mod
  import qpsk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_bit,
  output logic                    in_ready,
  output logic signed [OUT_W-1:0] sample_out,
  output logic                    sample_valid,
  output logic                    underrun
);
  logic               full;
  logic [SYM_W-1:0]   sym;
  logic               take;
  logic [PHASE_W-1:0] phase;

  qpsk_sym_collect #(.BITS(SYM_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .take     (take),
    .in_ready (in_ready),
    .full     (full),
    .sym      (sym)
  );

  qpsk_phase_gen #(
    .PW   (PHASE_W),
    .STEP (PHASE_STEP),
    .NSYM (SAMP_PER_SYM),
    .CW   (CNT_W)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .full     (full),
    .sym      (sym),
    .take     (take),
    .phase    (phase),
    .underrun (underrun)
  );

  qpsk_sine_lut #(
    .PW (PHASE_W),
    .AW (LUT_AW),
    .OW (OUT_W)
  ) u_lut (
    .clk          (clk),
    .rst_n        (rst_n),
    .phase        (phase),
    .sample_out   (sample_out),
    .sample_valid (sample_valid)
  );
endmodule

// File: tb/qpsk_phase_mod_tb_top.sv
module qpsk_phase_mod_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_bit;
  logic        in_ready;
  logic [15:0] sample_out;
  logic        sample_valid;
  logic        underrun;

  int checks = 0;
  int errors = 0;

  // model state
  int   c;
  int   mcount;
  logic [1:0] mshift;
  int   mq;
  int   qhist [0:1023];
  logic bits [0:63];
  int   nbits, bitptr, feed_start;
  logic drove, ready_seen, bit_drv;
  int   exp_under;
  string cur_tag;

  always #10 clk = ~clk;  // 50 MHz

  qpsk_phase_mod dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_bit       (in_bit),
    .in_ready     (in_ready),
    .sample_out   (sample_out),
    .sample_valid (sample_valid),
    .underrun     (underrun)
  );

  function automatic int table_val(int k);
    case (k)
      0: return 32767;
      1: return 23170;
      2: return 0;
      3: return -23170;
      4: return -32767;
      5: return -23170;
      6: return 0;
      default: return 23170;
    endcase
  endfunction

  function automatic int quarter_of(logic [1:0] s);
    case (s)
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, c, act, exp);
    end
  endtask

  task automatic drive();
    if (c >= feed_start && bitptr < nbits) begin
      in_valid   = 1'b1;
      in_bit     = bits[bitptr];
      bit_drv    = bits[bitptr];
      drove      = 1'b1;
      ready_seen = in_ready;
      if (in_ready) bitptr++;
    end else begin
      in_valid = 1'b0;
      in_bit   = 1'b0;
      drove    = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_bit   = 1'b0;
    drove    = 1'b0;
    repeat (3) @(negedge clk);
    check(sample_out == 16'd0, "R6 reset sample", int'($signed(sample_out)), 0);
    check(sample_valid == 1'b0, "R6 reset valid", int'(sample_valid), 0);
    check(underrun == 1'b0, "R6 reset underrun", int'(underrun), 0);
    check(in_ready == 1'b1, "R6 reset ready", int'(in_ready), 1);
    c = 0; mcount = 0; mshift = 2'b00; mq = 0; qhist[0] = 0; bitptr = 0;
    rst_n = 1'b1;
    drive();
  endtask

  task automatic step();
    int j, k;
    string t;
    @(posedge clk);
    c++;
    exp_under = 0;
    if (c % 40 == 0) begin
      exp_under = (mcount != 2) ? 1 : 0;
      if (mcount == 2) begin
        mq = quarter_of(mshift);
        mcount = 0;
      end
    end
    if (drove && ready_seen) begin
      mshift = {mshift[0], bit_drv};
      mcount++;
    end
    qhist[c] = mq;
    @(negedge clk);
    check(sample_valid == (c >= 2), "R7 valid timing", int'(sample_valid), int'(c >= 2));
    check(underrun == exp_under[0], "R5 underrun", int'(underrun), exp_under);
    check(in_ready == (mcount != 2), "R1 ready", int'(in_ready), int'(mcount != 2));
    if (c >= 2) begin
      j = c - 2;
      k = (j % 8 + 2 * qhist[j]) % 8;
      if (j == 0) t = "R6 first sample";
      else if (j % 40 == 0) t = "R4 symbol start";
      else t = cur_tag;
      check($signed(sample_out) == table_val(k), t, int'($signed(sample_out)), table_val(k));
      check($signed(sample_out) >= -32767, "R8 bound", int'($signed(sample_out)), -32767);
    end
    drive();
  endtask

  task automatic load2(int i, logic b1, logic b0);
    bits[2*i]   = b1;
    bits[2*i+1] = b0;
  endtask

  // R2, R3, R1: all four symbols streamed back to back
  task automatic t_all_symbols();
    cur_tag = "R2 mapping";
    load2(0, 1'b0, 1'b0); load2(1, 1'b0, 1'b1);
    load2(2, 1'b1, 1'b1); load2(3, 1'b1, 1'b0);
    nbits = 8; feed_start = 0;
    do_reset();
    repeat (240) step();
  endtask

  // R5, R4: data arrives after the first boundary
  task automatic t_late_feed();
    cur_tag = "R3 carrier";
    load2(0, 1'b1, 1'b1); load2(1, 1'b0, 1'b1);
    nbits = 4; feed_start = 60;
    do_reset();
    repeat (200) step();
  endtask

  // R5: one symbol, then repeated underruns holding 270 degrees
  task automatic t_underrun_hold();
    cur_tag = "R5 hold";
    load2(0, 1'b1, 1'b0);
    nbits = 2; feed_start = 0;
    do_reset();
    repeat (170) step();
  endtask

  // R1: order check, 10 then 01 must differ (MSB first)
  task automatic t_bit_order();
    cur_tag = "R1 order";
    load2(0, 1'b0, 1'b1); load2(1, 1'b1, 1'b0); load2(2, 1'b1, 1'b0);
    nbits = 6; feed_start = 5;
    do_reset();
    repeat (130) step();
  endtask

  initial begin
    #(20ns * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_all_symbols();
    t_late_feed();
    t_underrun_hold();
    t_bit_order();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule